// File: doc/BRIEF.md
# Dual-Window Indexed Configuration Port

This block holds a chipset's configuration register array behind an indexed I/O interface. Software first writes a register number to an index port. It then reads or writes that register through the matching data port. There are two index/data pairs. The normal pair sits at I/O 22h (index) and 23h (data). The management pair sits at 26h (index) and 27h (data). Both pairs reach the same register array. Each pair has its own stored index and its own "index loaded" flag. A management handler can therefore run a complete register access between the index write and the data access of an interrupted normal-mode sequence, and the normal sequence still completes correctly afterwards.

Port 70h cannot be read on the bus. The block watches writes to port 70h and keeps a copy of the last value, which reads back as configuration register 96h. The whole register array is driven out as a flat bus. Bit 2 of register 94h also has its own output, which goes to the address-line-20 forcing logic.

Top module: `cfgw_top`

## Requirements
- R1: Reset clears both stored indexes, both loaded flags and every configuration register to 00h. A data port read straight after reset returns FFh.
- R2: A write to 22h stores the index and sets the normal window's flag. The next write to 23h stores the data byte into the indexed register, and the next read of 23h returns that register.
- R3: Data written through the 26h/27h pair can be read through the 22h/23h pair, and the reverse also holds, because both pairs address one array.
- R4: The index stored by 26h is separate from the index stored by 22h. Loading one never changes which register the other pair's data port reaches.
- R5: A data port access consumes the flag. A later data access without a new index write leaves every register unchanged, and a read in that state returns FFh.
- R6: An index write to one pair never sets or clears the flag of the other pair.
- R7: Every write to I/O 70h is captured into register 96h, and register 96h reads back that value through either data port.
- R8: Writes to register 96h through either data port are ignored.
- R9: Output `a20_force_en` follows bit 2 of register 94h.
- R10: A read of any address other than 23h or 27h returns FFh, including a read of 70h.
- R11: `cfg_regs` carries register n on bits [8n+7:8n].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_addr | input | 16 | I/O address |
| io_wr | input | 1 | Write strobe, one cycle per access |
| io_rd | input | 1 | Read strobe, one cycle per access |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data, valid in the same cycle as io_rd |
| cfg_regs | output | 2048 | All configuration registers, flattened |
| a20_force_en | output | 1 | Register 94h bit 2 |

## Verification
The bench interleaves the two windows. It loads 22h, then runs a full 26h/27h access, then finishes the 23h access. A design with a shared index latch or a shared flag would return the register last chosen by the management pair, or would return FFh. It repeats data accesses without reloading the index, where a design that keeps the flag set would write or read a second time. It also writes 96h through the data ports and reads port 70h directly. A design that lets the shadow register be written through a data port, or that decodes 70h for reads, would return the wrong byte.

// File: rtl/cfgw_pkg.sv
package cfgw_pkg;
  // Number of index/data windows and their roles
  localparam int NWIN = 2;
  typedef enum logic [0:0] {WIN_NORM = 1'b0, WIN_MGMT = 1'b1} win_e;

  // Per-window decoded request for one bus cycle
  typedef struct packed {
    logic idx_wr;
    logic dat_wr;
    logic dat_rd;
  } win_req_t;

  // Default I/O map
  localparam logic [15:0] NORM_IDX_PORT = 16'h0022;
  localparam logic [15:0] NORM_DAT_PORT = 16'h0023;
  localparam logic [15:0] MGMT_IDX_PORT = 16'h0026;
  localparam logic [15:0] MGMT_DAT_PORT = 16'h0027;
  localparam logic [15:0] SNOOP_PORT    = 16'h0070;

  localparam logic [7:0] IDLE_BYTE = 8'hFF;
endpackage

// File: rtl/cfgw_decode.sv
module cfgw_decode
  import cfgw_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic [AW-1:0] io_addr,
  input  logic          io_wr,
  input  logic          io_rd,
  output win_req_t      req [NWIN],
  output logic          snoop_wr
);
  localparam logic [AW-1:0] SNOOP_A = AW'(SNOOP_PORT);

  for (genvar w = 0; w < NWIN; w++) begin : g_win
    localparam logic [AW-1:0] IDX_A = (w == int'(WIN_NORM)) ? AW'(NORM_IDX_PORT) : AW'(MGMT_IDX_PORT);
    localparam logic [AW-1:0] DAT_A = (w == int'(WIN_NORM)) ? AW'(NORM_DAT_PORT) : AW'(MGMT_DAT_PORT);
    always_comb begin
      req[w].idx_wr = io_wr && (io_addr == IDX_A);
      req[w].dat_wr = io_wr && (io_addr == DAT_A);
      req[w].dat_rd = io_rd && (io_addr == DAT_A);
    end
  end

  assign snoop_wr = io_wr && (io_addr == SNOOP_A);
endmodule

// File: rtl/cfgw_window.sv
module cfgw_window
  import cfgw_pkg::*;
#(
  parameter int IW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  win_req_t      req,
  input  logic [7:0]    wdata,
  output logic [IW-1:0] idx,
  output logic          loaded
);
  logic [IW-1:0] idx_d;
  logic          loaded_d;
  logic          idx_en;
  logic          loaded_en;

  always_comb begin
    idx_en    = req.idx_wr;
    idx_d     = IW'(wdata);
    loaded_en = req.idx_wr || req.dat_wr || req.dat_rd;
    loaded_d  = req.idx_wr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx <= '0;
    end else if (idx_en) begin
      idx <= idx_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      loaded <= 1'b0;
    end else if (loaded_en) begin
      loaded <= loaded_d;
    end
  end
endmodule

// File: rtl/cfgw_regfile.sv
module cfgw_regfile #(
  parameter int NREG   = 256,
  parameter int IW     = 8,
  parameter int RO_IDX = 'h96
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [IW-1:0]   wr_idx,
  input  logic [7:0]      wr_data,
  input  logic            snoop_wr,
  input  logic [7:0]      snoop_data,
  input  logic [IW-1:0]   rd_idx,
  output logic [7:0]      rd_data,
  output logic [NREG*8-1:0] flat
);
  logic [7:0] regs [NREG];

  for (genvar r = 0; r < NREG; r++) begin : g_reg
    logic [7:0] reg_d;
    logic       reg_en;
    always_comb begin
      if (r == RO_IDX) begin
        reg_en = snoop_wr;
        reg_d  = snoop_data;
      end else begin
        reg_en = wr_en && (int'(wr_idx) == r);
        reg_d  = wr_data;
      end
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        regs[r] <= 8'h00;
      end else if (reg_en) begin
        regs[r] <= reg_d;
      end
    end
    assign flat[r*8 +: 8] = regs[r];
  end

  always_comb begin
    rd_data = 8'h00;
    if (int'(rd_idx) < NREG) begin
      rd_data = regs[rd_idx];
    end
  end
endmodule

// File: rtl/cfgw_top.sv
module cfgw_top
  import cfgw_pkg::*;
#(
  parameter int AW      = 16,
  parameter int NREG    = 256,
  parameter int RO_IDX  = 'h96,
  parameter int A20_REG = 'h94,
  parameter int A20_BIT = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [AW-1:0]     io_addr,
  input  logic              io_wr,
  input  logic              io_rd,
  input  logic [7:0]        io_wdata,
  output logic [7:0]        io_rdata,
  output logic [NREG*8-1:0] cfg_regs,
  output logic              a20_force_en
);
  localparam int IW = 8;

  win_req_t      req [NWIN];
  logic          snoop_wr;
  logic [IW-1:0] win_idx [NWIN];
  logic [NWIN-1:0] win_loaded;
  logic [NWIN-1:0] win_wr_hit;
  logic [NWIN-1:0] win_rd_hit;
  logic          arr_wr_en;
  logic [IW-1:0] arr_idx;
  logic [7:0]    arr_rdata;

  cfgw_decode #(.AW(AW)) u_dec (
    .io_addr  (io_addr),
    .io_wr    (io_wr),
    .io_rd    (io_rd),
    .req      (req),
    .snoop_wr (snoop_wr)
  );

  for (genvar w = 0; w < NWIN; w++) begin : g_win
    cfgw_window #(.IW(IW)) u_win (
      .clk    (clk),
      .rst_n  (rst_n),
      .req    (req[w]),
      .wdata  (io_wdata),
      .idx    (win_idx[w]),
      .loaded (win_loaded[w])
    );
    assign win_wr_hit[w] = req[w].dat_wr && win_loaded[w];
    assign win_rd_hit[w] = req[w].dat_rd && win_loaded[w];
  end

  // At most one window is addressed per bus cycle
  always_comb begin
    arr_wr_en = |win_wr_hit;
    if (req[WIN_MGMT].dat_wr || req[WIN_MGMT].dat_rd) begin
      arr_idx = win_idx[WIN_MGMT];
    end else begin
      arr_idx = win_idx[WIN_NORM];
    end
  end

  cfgw_regfile #(.NREG(NREG), .IW(IW), .RO_IDX(RO_IDX)) u_rf (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (arr_wr_en),
    .wr_idx     (arr_idx),
    .wr_data    (io_wdata),
    .snoop_wr   (snoop_wr),
    .snoop_data (io_wdata),
    .rd_idx     (arr_idx),
    .rd_data    (arr_rdata),
    .flat       (cfg_regs)
  );

  always_comb begin
    io_rdata = (|win_rd_hit) ? arr_rdata : IDLE_BYTE;
  end

  assign a20_force_en = cfg_regs[A20_REG*8 + A20_BIT];
endmodule

// File: rtl/cfgw_checker.sv
module cfgw_checker #(
  parameter int AW     = 16,
  parameter int NREG   = 256,
  parameter int RO_IDX = 'h96
) (
  input logic              clk,
  input logic              rst_n,
  input logic [AW-1:0]     io_addr,
  input logic              io_wr,
  input logic              io_rd,
  input logic [7:0]        io_wdata,
  input logic [7:0]        io_rdata,
  input logic [NREG*8-1:0] cfg_regs,
  input logic [1:0]        loaded
);
  logic norm_dat, mgmt_dat, any_dat;
  assign norm_dat = io_addr == AW'(16'h0023);
  assign mgmt_dat = io_addr == AW'(16'h0027);
  assign any_dat  = norm_dat || mgmt_dat;

  AST_RESET_CLEARS: assert property (@(posedge clk) !rst_n |-> (cfg_regs == '0 && loaded == 2'b00)); // R1
  AST_IDX_LOADS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && io_addr == AW'(16'h0022)) |=> loaded[0]); // R2
  AST_STALE_WRITE_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && norm_dat && !loaded[0]) |=> $stable(cfg_regs)); // R5
  AST_FLAGS_INDEPENDENT: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && io_addr == AW'(16'h0026)) |=> $stable(loaded[0])); // R6
  AST_SNOOP_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && io_addr == AW'(16'h0070)) |=> cfg_regs[RO_IDX*8 +: 8] == $past(io_wdata)); // R7
  AST_SHADOW_READ_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && any_dat) |=> $stable(cfg_regs[RO_IDX*8 +: 8])); // R8
  AST_OTHER_READ_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rd && !any_dat) |-> io_rdata == 8'hFF); // R10
endmodule

bind cfgw_top cfgw_checker #(.AW(AW), .NREG(NREG), .RO_IDX(RO_IDX)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .io_addr  (io_addr),
  .io_wr    (io_wr),
  .io_rd    (io_rd),
  .io_wdata (io_wdata),
  .io_rdata (io_rdata),
  .cfg_regs (cfg_regs),
  .loaded   (win_loaded)
);

// File: tb/cfgw_top_bench.sv
module cfgw_top_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NREG = 256;

  logic              clk;
  logic              rst_n;
  logic [15:0]       io_addr;
  logic              io_wr;
  logic              io_rd;
  logic [7:0]        io_wdata;
  logic [7:0]        io_rdata;
  logic [NREG*8-1:0] cfg_regs;
  logic              a20_force_en;

  int checks = 0;
  int errors = 0;

  cfgw_top u_cfgw_top (
    .clk          (clk),
    .rst_n        (rst_n),
    .io_addr      (io_addr),
    .io_wr        (io_wr),
    .io_rd        (io_rd),
    .io_wdata     (io_wdata),
    .io_rdata     (io_rdata),
    .cfg_regs     (cfg_regs),
    .a20_force_en (a20_force_en)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // Vector: {op(1=read and check, 0=write), req number(4), addr(16), data/expected(8)}
  localparam int NVEC = 31;
  localparam logic [28:0] VEC [NVEC] = '{
    {1'b1, 4'd1,  16'h0023, 8'hFF},  // R1 flag clear after reset
    {1'b0, 4'd2,  16'h0022, 8'h10},
    {1'b0, 4'd2,  16'h0023, 8'hA5},
    {1'b0, 4'd2,  16'h0022, 8'h10},
    {1'b1, 4'd2,  16'h0023, 8'hA5},  // R2 read back
    {1'b1, 4'd5,  16'h0023, 8'hFF},  // R5 flag consumed
    {1'b0, 4'd5,  16'h0023, 8'h77},  // R5 stale write
    {1'b0, 4'd5,  16'h0022, 8'h10},
    {1'b1, 4'd5,  16'h0023, 8'hA5},  // R5 register unchanged
    {1'b0, 4'd3,  16'h0026, 8'h20},
    {1'b0, 4'd3,  16'h0027, 8'h3C},
    {1'b0, 4'd3,  16'h0022, 8'h20},
    {1'b1, 4'd3,  16'h0023, 8'h3C},  // R3 shared array
    {1'b0, 4'd4,  16'h0022, 8'h10},
    {1'b0, 4'd4,  16'h0026, 8'h20},
    {1'b1, 4'd4,  16'h0027, 8'h3C},  // R4 mgmt index kept
    {1'b1, 4'd4,  16'h0023, 8'hA5},  // R4 normal index kept
    {1'b0, 4'd6,  16'h0026, 8'h30},
    {1'b1, 4'd6,  16'h0023, 8'hFF},  // R6 normal flag not set
    {1'b1, 4'd6,  16'h0027, 8'h00},  // R6 mgmt flag still set
    {1'b0, 4'd7,  16'h0070, 8'h8B},
    {1'b0, 4'd7,  16'h0026, 8'h96},
    {1'b1, 4'd7,  16'h0027, 8'h8B},  // R7 shadow readable
    {1'b1, 4'd10, 16'h0070, 8'hFF},  // R10 port 70h not readable
    {1'b0, 4'd8,  16'h0022, 8'h96},
    {1'b0, 4'd8,  16'h0023, 8'h11},
    {1'b0, 4'd8,  16'h0026, 8'h96},
    {1'b0, 4'd8,  16'h0027, 8'h12},
    {1'b0, 4'd8,  16'h0022, 8'h96},
    {1'b1, 4'd8,  16'h0023, 8'h8B},  // R8 writes ignored
    {1'b1, 4'd10, 16'h0022, 8'hFF}   // R10 index port read
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic bus(input bit rd, input logic [15:0] a, input logic [7:0] d, output logic [7:0] got);
    @(negedge clk);
    io_addr = a;
    io_wr = !rd;
    io_rd = rd;
    io_wdata = rd ? 8'h00 : d;
    #1;
    got = io_rdata;
    @(posedge clk);
    #1;
    io_wr = 1'b0;
    io_rd = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] got;
    rst_n = 1'b0;
    io_addr = '0;
    io_wr = 1'b0;
    io_rd = 1'b0;
    io_wdata = '0;
    repeat (3) @(posedge clk);
    #1;
    check("R1 regs zero", {7'd0, cfg_regs == '0}, 8'h01);
    @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < NVEC; i++) begin
      bus(VEC[i][28], VEC[i][23:8], VEC[i][7:0], got);
      if (VEC[i][28]) check($sformatf("R%0d vec %0d", VEC[i][27:24], i), got, VEC[i][7:0]);
    end

    // R9 and R11: set 94h bit 2, then clear it through the other window
    bus(1'b0, 16'h0022, 8'h94, got);
    bus(1'b0, 16'h0023, 8'h04, got);
    #1;
    check("R9 a20 set", {7'd0, a20_force_en}, 8'h01);
    check("R11 byte 94h", cfg_regs[8'h94*8 +: 8], 8'h04);
    check("R11 byte 10h", cfg_regs[8'h10*8 +: 8], 8'hA5);
    bus(1'b0, 16'h0026, 8'h94, got);
    bus(1'b0, 16'h0027, 8'hFB, got);
    #1;
    check("R9 a20 clear", {7'd0, a20_force_en}, 8'h00);

    // R1: reset in the middle of a sequence
    bus(1'b0, 16'h0022, 8'h10, got);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R1 regs cleared", {7'd0, cfg_regs == '0}, 8'h01);
    @(negedge clk);
    rst_n = 1'b1;
    bus(1'b1, 16'h0023, 8'h00, got);
    check("R1 flag cleared", got, 8'hFF);
    bus(1'b0, 16'h0026, 8'h00, got);
    bus(1'b1, 16'h0027, 8'h00, got);
    check("R1 reg 00h value", got, 8'h00);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule